// File: doc/BRIEF.md
# Pipeline Hazard Stall and Bubble Controller

This block is the central control unit of a five-stage in-order processor pipeline (fetch, decode, execute, memory, write-back). It looks at the operation codes, register identifiers, branch outcomes and status codes that each stage presents, and works out, in the same cycle, whether each pipeline register should load, hold (stall) or load a no-operation pattern (bubble). From those inputs it also selects where the next fetch address comes from, and it gates the condition-flag and data-memory writes while a faulting instruction is draining.

Four hazard rules are merged into one set of per-stage controls, each with a fixed cost. A load followed at once by a consumer of the loaded register costs one bubble. A branch that was predicted taken but resolves not taken costs two squashed slots. A return instruction holds fetch until it reaches write-back, which costs three bubbles. A fault in the memory or write-back stage freezes state updates. The write-back stage register, which carries the operation code and status, sits inside the block. It is built from a parameterised pipeline register with stall and bubble inputs. Its contents give the reported machine status, so the instruction furthest down the pipeline always decides what is reported.

Top module: `hazard_ctl`

## Requirements
- R1: Operation codes are 4 bits: 0 halt, 1 no-op, 4 store, 5 load, 6 arithmetic, 7 branch, 8 call, 9 return, 0xA push, 0xB pop; register id 0xF means no register. A load-use hazard exists when the execute code is 5 or 0xB, e_dstm is not 0xF, and e_dstm equals d_srca or d_srcb. During a load-use hazard f_stall=1, d_stall=1 and e_bubble=1.
- R2: When code 9 is present in decode, execute or memory, f_stall=1. If neither a load-use hazard nor a mispredict is also present, d_bubble=1.
- R3: A mispredict exists when the execute code is 7 and e_cnd=0. It drives d_bubble=1 and e_bubble=1 with d_stall=0.
- R4: When a load-use hazard and a pending return occur together, d_stall=1 and d_bubble=0.
- R5: When a mispredict and a pending return occur together, the squash wins: d_bubble=1, e_bubble=1 and d_stall=0.
- R6: pc_sel=1 (fall-through address from memory stage) when the memory code is 7 with m_cnd=0. Otherwise pc_sel=2 (return address) when the write-back code is 9. Otherwise pc_sel=0 (predicted address). The value 3 never appears.
- R7: Status is 3 bits: 1 running, 2 halted, 3 address fault, 4 illegal code. When m_stat or the write-back status is not 1, m_bubble=1, cc_wen=0 and dmem_wen=0.
- R8: With no fault, cc_wen=1 exactly when the execute code is 6. dmem_wen=1 exactly when the memory code is 4, 8 or 0xA.
- R9: The write-back register loads {m_icode, m_stat} on each rising clock edge and resets to code 1 with status 1. core_stat shows its status. While that status is not 1, w_stall=1 and halted=1, and the register keeps its value.
- R10: f_bubble, e_stall, m_stall and w_bubble are always 0. With no hazard and no fault, every stall and bubble output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| d_icode | input | 4 | Operation code in decode |
| d_srca | input | 4 | First source register id in decode |
| d_srcb | input | 4 | Second source register id in decode |
| e_icode | input | 4 | Operation code in execute |
| e_dstm | input | 4 | Memory-result destination id in execute |
| e_cnd | input | 1 | Branch condition computed in execute |
| m_icode | input | 4 | Operation code in memory stage |
| m_cnd | input | 1 | Branch condition carried in memory stage |
| m_stat | input | 3 | Status of memory-stage instruction |
| f_stall | output | 1 | Hold fetch register |
| f_bubble | output | 1 | Bubble fetch register |
| d_stall | output | 1 | Hold decode register |
| d_bubble | output | 1 | Bubble decode register |
| e_stall | output | 1 | Hold execute register |
| e_bubble | output | 1 | Bubble execute register |
| m_stall | output | 1 | Hold memory register |
| m_bubble | output | 1 | Bubble memory register |
| w_stall | output | 1 | Hold write-back register |
| w_bubble | output | 1 | Bubble write-back register |
| pc_sel | output | 2 | Fetch address source select |
| cc_wen | output | 1 | Condition-flag write enable |
| dmem_wen | output | 1 | Data-memory write enable |
| core_stat | output | 3 | Status held in write-back |
| halted | output | 1 | Write-back status is not running |

## Verification
All stall, bubble, select and enable outputs are combinational in the stage inputs and the write-back register, so they are due in the same cycle: the bench drives inputs just after a falling edge and samples one time unit later, well before the next rising edge. core_stat, halted, w_stall and the return-address select follow the memory-stage inputs one rising edge later. Those checks drive the inputs, wait for that single edge, and then sample after it has settled. The bench keeps its own record of the expected write-back status, so the frozen-status case is checked across several later edges.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int ICW  = 4;
  localparam int RIDW = 4;
  localparam int STW  = 3;

  typedef logic [ICW-1:0]  icode_t;
  typedef logic [RIDW-1:0] rid_t;
  typedef logic [STW-1:0]  stat_t;

  localparam icode_t IC_HALT   = 4'h0;
  localparam icode_t IC_NOP    = 4'h1;
  localparam icode_t IC_STORE  = 4'h4;
  localparam icode_t IC_LOAD   = 4'h5;
  localparam icode_t IC_ALU    = 4'h6;
  localparam icode_t IC_BRANCH = 4'h7;
  localparam icode_t IC_CALL   = 4'h8;
  localparam icode_t IC_RET    = 4'h9;
  localparam icode_t IC_PUSH   = 4'hA;
  localparam icode_t IC_POP    = 4'hB;

  localparam rid_t RID_NONE = {RIDW{1'b1}};

  localparam stat_t ST_RUN     = 3'd1;
  localparam stat_t ST_HALT    = 3'd2;
  localparam stat_t ST_ADDR    = 3'd3;
  localparam stat_t ST_ILLEGAL = 3'd4;

  typedef enum logic [1:0] {
    PCS_PRED     = 2'd0,
    PCS_FALLTHRU = 2'd1,
    PCS_RETADDR  = 2'd2
  } pcsel_t;

  typedef struct packed {
    logic stall;
    logic bubble;
  } regctl_t;

  localparam int NSTAGE = 5;
  localparam int WB_W   = ICW + STW;

  function automatic logic fills_from_memory(icode_t ic);
    return (ic == IC_LOAD) || (ic == IC_POP);
  endfunction

  function automatic logic writes_memory(icode_t ic);
    return (ic == IC_STORE) || (ic == IC_PUSH) || (ic == IC_CALL);
  endfunction

  function automatic logic is_fault(stat_t st);
    return st != ST_RUN;
  endfunction

  function automatic logic reg_depends(rid_t src, rid_t dst);
    return (dst != RID_NONE) && (src == dst);
  endfunction
endpackage

// File: rtl/hz_pipe_reg.sv
module hz_pipe_reg #(
  parameter int          W          = 8,
  parameter logic [W-1:0] BUBBLE_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stall,
  input  logic         bubble,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= BUBBLE_VAL;
    else if (bubble) q <= BUBBLE_VAL;
    else if (!stall) q <= d;
  end

  // R9: a held register keeps its contents across the edge
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !bubble) |=> (q == $past(q)));
  // R9: a loading register takes its input
  a_r9_load_takes_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !bubble) |=> (q == $past(d)));
endmodule

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
(
  input  icode_t d_icode,
  input  rid_t   d_srca,
  input  rid_t   d_srcb,
  input  icode_t e_icode,
  input  rid_t   e_dstm,
  input  logic   e_cnd,
  input  icode_t m_icode,
  input  stat_t  m_stat,
  input  stat_t  w_stat,
  output logic   loaduse,
  output logic   ret_pending,
  output logic   mispredict,
  output logic   m_fault,
  output logic   w_fault
);
  always_comb begin
    loaduse = fills_from_memory(e_icode) &&
              (reg_depends(d_srca, e_dstm) || reg_depends(d_srcb, e_dstm));
    ret_pending = (d_icode == IC_RET) || (e_icode == IC_RET) || (m_icode == IC_RET);
    mispredict  = (e_icode == IC_BRANCH) && !e_cnd;
    m_fault     = is_fault(m_stat);
    w_fault     = is_fault(w_stat);
  end
endmodule

// File: rtl/hz_stage_ctl.sv
module hz_stage_ctl
  import hz_pkg::*;
(
  input  logic    loaduse,
  input  logic    ret_pending,
  input  logic    mispredict,
  input  logic    m_fault,
  input  logic    w_fault,
  output regctl_t ctl [NSTAGE]
);
  // stage index: 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back
  localparam int SF = 0, SD = 1, SE = 2, SM = 3, SW = 4;

  logic [NSTAGE-1:0] stall_v, bubble_v;

  always_comb begin
    stall_v  = '0;
    bubble_v = '0;
    stall_v[SF]  = loaduse || ret_pending;
    stall_v[SD]  = loaduse && !mispredict;
    bubble_v[SD] = mispredict || (ret_pending && !loaduse);
    bubble_v[SE] = mispredict || loaduse;
    bubble_v[SM] = m_fault || w_fault;
    stall_v[SW]  = w_fault;
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_pack
    assign ctl[s].stall  = stall_v[s];
    assign ctl[s].bubble = bubble_v[s];
  end
endmodule

// File: rtl/hz_flow_sel.sv
module hz_flow_sel
  import hz_pkg::*;
(
  input  icode_t m_icode,
  input  logic   m_cnd,
  input  icode_t w_icode,
  input  logic   e_is_alu,
  input  logic   freeze,
  output pcsel_t pc_sel,
  output logic   cc_wen,
  output logic   dmem_wen
);
  always_comb begin
    if ((m_icode == IC_BRANCH) && !m_cnd) pc_sel = PCS_FALLTHRU;
    else if (w_icode == IC_RET)           pc_sel = PCS_RETADDR;
    else                                  pc_sel = PCS_PRED;
    cc_wen   = e_is_alu && !freeze;
    dmem_wen = writes_memory(m_icode) && !freeze;
  end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] d_icode,
  input  logic [3:0] d_srca,
  input  logic [3:0] d_srcb,
  input  logic [3:0] e_icode,
  input  logic [3:0] e_dstm,
  input  logic       e_cnd,
  input  logic [3:0] m_icode,
  input  logic       m_cnd,
  input  logic [2:0] m_stat,
  output logic       f_stall,
  output logic       f_bubble,
  output logic       d_stall,
  output logic       d_bubble,
  output logic       e_stall,
  output logic       e_bubble,
  output logic       m_stall,
  output logic       m_bubble,
  output logic       w_stall,
  output logic       w_bubble,
  output logic [1:0] pc_sel,
  output logic       cc_wen,
  output logic       dmem_wen,
  output logic [2:0] core_stat,
  output logic       halted
);
  logic    loaduse, ret_pending, mispredict, m_fault, w_fault;
  regctl_t ctl [NSTAGE];
  icode_t  w_icode;
  stat_t   w_stat;
  pcsel_t  pc_sel_e;
  logic [WB_W-1:0] wb_q;

  hz_detect u_detect (
    .d_icode(d_icode), .d_srca(d_srca), .d_srcb(d_srcb),
    .e_icode(e_icode), .e_dstm(e_dstm), .e_cnd(e_cnd),
    .m_icode(m_icode), .m_stat(m_stat), .w_stat(w_stat),
    .loaduse(loaduse), .ret_pending(ret_pending), .mispredict(mispredict),
    .m_fault(m_fault), .w_fault(w_fault)
  );

  hz_stage_ctl u_stage (
    .loaduse(loaduse), .ret_pending(ret_pending), .mispredict(mispredict),
    .m_fault(m_fault), .w_fault(w_fault), .ctl(ctl)
  );

  hz_flow_sel u_flow (
    .m_icode(m_icode), .m_cnd(m_cnd), .w_icode(w_icode),
    .e_is_alu(e_icode == IC_ALU), .freeze(m_fault || w_fault),
    .pc_sel(pc_sel_e), .cc_wen(cc_wen), .dmem_wen(dmem_wen)
  );

  hz_pipe_reg #(.W(WB_W), .BUBBLE_VAL({IC_NOP, ST_RUN})) u_wb_reg (
    .clk(clk), .rst_n(rst_n),
    .stall(ctl[4].stall), .bubble(ctl[4].bubble),
    .d({m_icode, m_stat}), .q(wb_q)
  );

  assign w_icode   = wb_q[WB_W-1:STW];
  assign w_stat    = wb_q[STW-1:0];
  assign core_stat = w_stat;
  assign halted    = w_fault;
  assign pc_sel    = pc_sel_e;

  assign f_stall  = ctl[0].stall;  assign f_bubble = ctl[0].bubble;
  assign d_stall  = ctl[1].stall;  assign d_bubble = ctl[1].bubble;
  assign e_stall  = ctl[2].stall;  assign e_bubble = ctl[2].bubble;
  assign m_stall  = ctl[3].stall;  assign m_bubble = ctl[3].bubble;
  assign w_stall  = ctl[4].stall;  assign w_bubble = ctl[4].bubble;

  // R1: a load-use hazard holds fetch and decode and empties execute
  a_r1_loaduse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    loaduse |-> (f_stall && e_bubble && (d_stall || mispredict)));
  // R2: a pending return keeps fetch parked
  a_r2_ret_parks_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pending |-> f_stall);
  // R3/R5: a squash empties decode and execute and never holds decode
  a_r3_squash: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> (d_bubble && e_bubble && !d_stall));
  // R4: decode is never both held and emptied
  a_r4_no_stall_and_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_stall && d_bubble));
  // R6: the fetch select never takes the unused code
  a_r6_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel != 2'd3);
  // R7: a fault late in the pipe blocks all state updates
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (m_fault || w_fault) |-> (!cc_wen && !dmem_wen && m_bubble));
  // R9: once halted, the reported status stays put
  a_r9_halt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(core_stat)));
  // R10: the unused controls stay low
  a_r10_quiet_controls: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_bubble || e_stall || m_stall || w_bubble));
endmodule

// File: tb/hazard_ctl_test.sv
module hazard_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] d_icode = 4'h1, d_srca = 4'hF, d_srcb = 4'hF;
  logic [3:0] e_icode = 4'h1, e_dstm = 4'hF;
  logic       e_cnd = 1'b1;
  logic [3:0] m_icode = 4'h1;
  logic       m_cnd = 1'b1;
  logic [2:0] m_stat = 3'd1;
  logic f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble;
  logic m_stall, m_bubble, w_stall, w_bubble, cc_wen, dmem_wen, halted;
  logic [1:0] pc_sel;
  logic [2:0] core_stat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [2:0] wstat_exp = 3'd1;
  logic [3:0] wcode_exp = 4'h1;

  hazard_ctl uut (
    .clk(clk), .rst_n(rst_n),
    .d_icode(d_icode), .d_srca(d_srca), .d_srcb(d_srcb),
    .e_icode(e_icode), .e_dstm(e_dstm), .e_cnd(e_cnd),
    .m_icode(m_icode), .m_cnd(m_cnd), .m_stat(m_stat),
    .f_stall(f_stall), .f_bubble(f_bubble), .d_stall(d_stall), .d_bubble(d_bubble),
    .e_stall(e_stall), .e_bubble(e_bubble), .m_stall(m_stall), .m_bubble(m_bubble),
    .w_stall(w_stall), .w_bubble(w_bubble), .pc_sel(pc_sel),
    .cc_wen(cc_wen), .dmem_wen(dmem_wen), .core_stat(core_stat), .halted(halted)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // expected {f_stall,f_bubble,d_stall,d_bubble,e_stall,e_bubble,m_stall,m_bubble,w_stall,w_bubble}
  function automatic logic [9:0] expected_ctl();
    logic hz_load, hz_ret, hz_br, hz_fault;
    logic [9:0] v;
    hz_load  = (e_icode == 4'h5 || e_icode == 4'hB) && e_dstm != 4'hF &&
               (d_srca == e_dstm || d_srcb == e_dstm);
    hz_ret   = (m_icode == 4'h9) || (e_icode == 4'h9) || (d_icode == 4'h9);
    hz_br    = (e_cnd == 1'b0) && (e_icode == 4'h7);
    hz_fault = (wstat_exp != 3'd1) || (m_stat != 3'd1);
    v = '0;
    v[9] = hz_ret | hz_load;
    if (hz_br) begin v[6] = 1'b1; v[4] = 1'b1; end
    else if (hz_load) begin v[7] = 1'b1; v[4] = 1'b1; end
    else if (hz_ret) v[6] = 1'b1;
    v[2] = hz_fault;
    v[1] = (wstat_exp != 3'd1);
    return v;
  endfunction

  function automatic logic [9:0] got_ctl();
    return {f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble,
            m_stall, m_bubble, w_stall, w_bubble};
  endfunction

  task automatic idle();
    @(negedge clk);
    d_icode = 4'h1; d_srca = 4'hF; d_srcb = 4'hF;
    e_icode = 4'h1; e_dstm = 4'hF; e_cnd = 1'b1;
    m_icode = 4'h1; m_cnd = 1'b1; m_stat = 3'd1;
  endtask

  task automatic settle_and_check_ctl(input string req);
    #1;
    check(req, got_ctl(), expected_ctl());
  endtask

  task automatic clock_wb();
    @(posedge clk);
    if (wstat_exp == 3'd1) begin wstat_exp = m_stat; wcode_exp = m_icode; end
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle();
    wstat_exp = 3'd1; wcode_exp = 4'h1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R9 reset status", core_stat, 1);
    check("R9 reset halted", halted, 0);
    check("R10 reset controls", got_ctl(), 0);
    check("R6 reset select", pc_sel, 0);
  endtask

  task automatic t_idle();
    idle(); d_icode = 4'h6; d_srca = 4'h2; e_icode = 4'h6; e_dstm = 4'h2;
    settle_and_check_ctl("R10 arithmetic producer no stall");
    check("R10 all zero", got_ctl(), 0);
    idle(); e_icode = 4'h7; e_cnd = 1'b1;
    settle_and_check_ctl("R3 taken branch no squash");
  endtask

  task automatic t_loaduse();
    idle(); e_icode = 4'h5; e_dstm = 4'h3; d_srca = 4'h3;
    settle_and_check_ctl("R1 load srcA");
    check("R1 stall bits", {f_stall, d_stall, e_bubble, d_bubble}, 4'b1110);
    idle(); e_icode = 4'hB; e_dstm = 4'h4; d_srcb = 4'h4;
    settle_and_check_ctl("R1 pop srcB");
    idle(); e_icode = 4'h5; e_dstm = 4'hF; d_srca = 4'hF;
    settle_and_check_ctl("R1 no-register id");
    check("R1 none stalls", f_stall, 0);
    idle(); e_icode = 4'h5; e_dstm = 4'h3; d_srca = 4'h2; d_srcb = 4'h1;
    settle_and_check_ctl("R1 no match");
  endtask

  task automatic t_ret();
    for (int s = 0; s < 3; s++) begin
      idle();
      if (s == 0) d_icode = 4'h9; else if (s == 1) e_icode = 4'h9; else m_icode = 4'h9;
      settle_and_check_ctl($sformatf("R2 return in stage %0d", s));
      check("R2 fetch parked", {f_stall, d_bubble}, 2'b11);
    end
  endtask

  task automatic t_mispredict();
    idle(); e_icode = 4'h7; e_cnd = 1'b0;
    settle_and_check_ctl("R3 mispredict");
    check("R3 squash bits", {d_stall, d_bubble, e_bubble}, 3'b011);
  endtask

  task automatic t_combo();
    idle(); e_icode = 4'h5; e_dstm = 4'h2; d_srca = 4'h2; m_icode = 4'h9;
    settle_and_check_ctl("R4 load-use with return");
    check("R4 decode held", {d_stall, d_bubble}, 2'b10);
    idle(); d_icode = 4'h9; e_icode = 4'h7; e_cnd = 1'b0;
    settle_and_check_ctl("R5 mispredict with return");
    check("R5 squash wins", {d_stall, d_bubble, e_bubble}, 3'b011);
  endtask

  task automatic t_pcsel();
    idle(); m_icode = 4'h7; m_cnd = 1'b0;
    #1 check("R6 fall-through", pc_sel, 1);
    idle(); m_icode = 4'h7; m_cnd = 1'b1;
    #1 check("R6 taken uses prediction", pc_sel, 0);
    idle(); m_icode = 4'h9;
    clock_wb();
    check("R6 return reached write-back", pc_sel, (wcode_exp == 4'h9) ? 2 : 0);
    check("R9 write-back code loaded", pc_sel, 2);
    @(negedge clk); m_icode = 4'h7; m_cnd = 1'b0;
    #1 check("R6 memory branch beats return", pc_sel, 1);
    idle();
    clock_wb();
    check("R6 back to prediction", pc_sel, 0);
  endtask

  task automatic t_commit();
    idle(); e_icode = 4'h6;
    #1 check("R8 flags on arithmetic", cc_wen, 1);
    idle(); e_icode = 4'h5;
    #1 check("R8 flags off for load", cc_wen, 0);
    idle(); m_icode = 4'h4;
    #1 check("R8 store writes", dmem_wen, 1);
    idle(); m_icode = 4'hA;
    #1 check("R8 push writes", dmem_wen, 1);
    idle(); m_icode = 4'h8;
    #1 check("R8 call writes", dmem_wen, 1);
    idle(); m_icode = 4'h5;
    #1 check("R8 load no write", dmem_wen, 0);
  endtask

  task automatic t_fault();
    idle(); e_icode = 4'h6; m_icode = 4'h4; m_stat = 3'd3;
    settle_and_check_ctl("R7 memory fault controls");
    check("R7 freeze", {m_bubble, cc_wen, dmem_wen}, 3'b100);
    check("R9 not yet halted", halted, 0);
    clock_wb();
    check("R9 status captured", core_stat, 3);
    check("R9 halted", {halted, w_stall}, 2'b11);
    @(negedge clk); m_stat = 3'd4; m_icode = 4'h1;
    clock_wb();
    check("R9 older fault kept", core_stat, 3);
    @(negedge clk); m_stat = 3'd1; e_icode = 4'h6; m_icode = 4'hA;
    settle_and_check_ctl("R7 write-back fault controls");
    check("R7 write-back freeze", {cc_wen, dmem_wen}, 2'b00);
    clock_wb();
    check("R9 still halted", core_stat, 3);
    do_reset();
    @(negedge clk); m_stat = 3'd2; m_icode = 4'h0;
    clock_wb();
    check("R9 halt status", core_stat, 2);
    check("R7 halt freezes flags", cc_wen, 0);
    do_reset();
  endtask

  initial begin
    t_reset();
    t_idle();
    t_loaduse();
    t_ret();
    t_mispredict();
    t_combo();
    t_pcsel();
    t_commit();
    t_fault();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule